// File: doc/BRIEF.md
# Descriptor-Driven Address Translation Walker

This block translates a virtual address into a physical address by following a chain of in-memory tables. A request carries the virtual address and a write flag. Privileged configuration supplies the root table address and the first index field, given as a bit offset and a width. The walker then reads one 64-bit descriptor per step through a single-outstanding read port.

Each descriptor decides how the walk continues. It can point at the next table or rewrite a field of the working address. It can drop write permission, and it selects the index field for the next step. It can also end the walk or stop it with a fault. Nothing about the level layout is fixed: every step is shaped by the descriptor just read.

When the walk ends, the table address held at that point is the physical address. A step cap stops walks through cyclic tables. Results stay on the outputs, with a single-cycle completion strobe.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready_o is 1, and mem_req_valid_o, done_o and fault_o are 0.
- R2: For the first read, the index is working-address bits [root_off_i +: root_width_i], with zeros beyond the address width. The read address is root_table_i + index*8, modulo 2^48.
- R3: A descriptor has bit 0 set (valid), bit 1 clear (not last) and bit 3 clear. Its bits 63:16 become the table address. Its bits 9:4 (offset) and 13:10 (width) give the index field for the next read.
- R4: A descriptor with bit 3 set keeps the table address. It overwrites working-address bits [offset +: width] with the low width bits of descriptor bits 63:16, using that descriptor's own offset and width. The next index is then taken from the rewritten address.
- R5: A valid descriptor with bit 1 set ends the walk. done_o pulses, fault_o is 0, and paddr_o is the table address after that descriptor is applied.
- R6: Descriptor bit 2 clears write permission, and nothing restores it within a walk. A write request whose last descriptor leaves the permission cleared ends with fault code 3 at that step. A read request on the same path succeeds.
- R7: A descriptor with bit 0 clear, or with bits 15:14 nonzero, ends the walk with fault code 1. fault_step_o is the 0-based number of that step, and paddr_o is 0 on any fault.
- R8: If the descriptor read at step MAX_STEPS-1 is valid and not last, the walk ends with fault code 2 and fault_step_o = MAX_STEPS-1.
- R9: At most one read is outstanding. mem_req_valid_o and mem_req_addr_o hold steady until mem_req_ready_i is seen.
- R10: req_ready_o is 1 only when idle. A request presented while a walk is running is ignored and does not change its result.
- R11: done_o is high for exactly one cycle per walk. paddr_o, fault_o, fault_code_o and fault_step_o stay stable until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | AW | Virtual address |
| req_write_i | input | 1 | Request is a write |
| root_table_i | input | 48 | Root table address |
| root_off_i | input | 6 | First index field bit offset |
| root_width_i | input | 4 | First index field width |
| mem_req_valid_o | output | 1 | Descriptor read request |
| mem_req_ready_i | input | 1 | Read request taken |
| mem_req_addr_o | output | 48 | Descriptor byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Descriptor |
| done_o | output | 1 | Completion strobe |
| fault_o | output | 1 | Walk ended in a fault |
| fault_code_o | output | 2 | 0 none, 1 bad descriptor, 2 depth, 3 write denied |
| fault_step_o | output | STEP_W | Step at which the walk ended |
| paddr_o | output | 48 | Physical address |

## Verification
The assertions assume the memory returns exactly one response per accepted read, always at least one cycle after the handshake, and never without a read pending. The assertions also assume the root configuration is meaningful only in the cycle a request is accepted. The bench memory answers only from its own pending slot, with a random delay of zero to two extra cycles, and it toggles its ready randomly to exercise request holding. Random descriptor chains are created lazily as the reference walk reaches each address. Their reserved bits are zero and their offsets stay inside the address width, so the inputs always keep within these assumptions.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int DESC_W = 64;
  localparam int PA_W   = 48;
  localparam int OFF_W  = 6;
  localparam int WID_W  = 4;
  localparam int IDX_W  = 16;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_DEPTH   = 2'd2,
    FLT_WRITE   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walk_st_e;

  typedef struct packed {
    logic [PA_W-1:0]  val;
    logic [1:0]       rsv;
    logic [WID_W-1:0] wid;
    logic [OFF_W-1:0] off;
    logic             rewrite;
    logic             clr_wp;
    logic             last;
    logic             valid;
  } desc_t;
endpackage

// File: rtl/ptw_index.sv
module ptw_index
  import ptw_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [WID_W-1:0] wid_i,
  input  logic [PA_W-1:0]  table_i,
  output logic [PA_W-1:0]  rd_addr_o
);
  logic [IDX_W-1:0] mask;
  logic [IDX_W-1:0] idx;

  assign mask      = (IDX_W'(1) << wid_i) - IDX_W'(1);
  assign idx       = IDX_W'(addr_i >> off_i) & mask;
  assign rd_addr_o = table_i + PA_W'({idx, 3'b000});
endmodule

// File: rtl/ptw_step.sv
module ptw_step
  import ptw_pkg::*;
#(
  parameter int AW        = 48,
  parameter int MAX_STEPS = 6,
  parameter int STEP_W    = 3
) (
  input  logic [DESC_W-1:0] desc_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [PA_W-1:0]   table_i,
  input  logic              wp_i,
  input  logic              write_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [AW-1:0]     nxt_addr_o,
  output logic [PA_W-1:0]   nxt_table_o,
  output logic              nxt_wp_o,
  output logic [OFF_W-1:0]  nxt_off_o,
  output logic [WID_W-1:0]  nxt_wid_o,
  output logic              finish_o,
  output fault_e            code_o
);
  desc_t         d;
  logic [63:0]   low_mask;
  logic [AW-1:0] fmask;
  logic [AW-1:0] fval;
  logic          good;
  logic          at_cap;

  assign d        = desc_t'(desc_i);
  assign low_mask = (64'd1 << d.wid) - 64'd1;
  assign fmask    = AW'(low_mask << d.off);
  assign fval     = AW'((64'(d.val) & low_mask) << d.off);
  assign good     = d.valid && (d.rsv == 2'b00);
  assign at_cap   = (step_i == STEP_W'(MAX_STEPS - 1));

  assign nxt_addr_o  = d.rewrite ? ((addr_i & ~fmask) | fval) : addr_i;
  assign nxt_table_o = d.rewrite ? table_i : d.val;
  assign nxt_wp_o    = wp_i & ~d.clr_wp;
  assign nxt_off_o   = d.off;
  assign nxt_wid_o   = d.wid;

  always_comb begin
    finish_o = 1'b1;
    code_o   = FLT_NONE;
    if (!good)       code_o = FLT_INVALID;
    else if (d.last) code_o = (write_i && !nxt_wp_o) ? FLT_WRITE : FLT_NONE;
    else if (at_cap) code_o = FLT_DEPTH;
    else             finish_o = 1'b0;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int AW        = 48,
  parameter int MAX_STEPS = 6,
  localparam int STEP_W   = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AW-1:0]     req_vaddr_i,
  input  logic              req_write_i,
  input  logic [47:0]       root_table_i,
  input  logic [5:0]        root_off_i,
  input  logic [3:0]        root_width_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [47:0]       mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [63:0]       mem_rsp_data_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        fault_code_o,
  output logic [STEP_W-1:0] fault_step_o,
  output logic [47:0]       paddr_o
);
  walk_st_e          state_q;
  logic [AW-1:0]     addr_q;
  logic [PA_W-1:0]   table_q;
  logic              wp_q, wr_q;
  logic [STEP_W-1:0] step_q;
  logic [OFF_W-1:0]  off_q;
  logic [WID_W-1:0]  wid_q;
  logic              done_q, fault_q;
  fault_e            code_q;
  logic [STEP_W-1:0] fstep_q;
  logic [PA_W-1:0]   paddr_q;

  logic [AW-1:0]     nxt_addr;
  logic [PA_W-1:0]   nxt_table;
  logic              nxt_wp;
  logic [OFF_W-1:0]  nxt_off;
  logic [WID_W-1:0]  nxt_wid;
  logic              finish;
  fault_e            code;

  ptw_index #(.AW(AW)) u_index (
    .addr_i    (addr_q),
    .off_i     (off_q),
    .wid_i     (wid_q),
    .table_i   (table_q),
    .rd_addr_o (mem_req_addr_o)
  );

  ptw_step #(.AW(AW), .MAX_STEPS(MAX_STEPS), .STEP_W(STEP_W)) u_step (
    .desc_i      (mem_rsp_data_i),
    .addr_i      (addr_q),
    .table_i     (table_q),
    .wp_i        (wp_q),
    .write_i     (wr_q),
    .step_i      (step_q),
    .nxt_addr_o  (nxt_addr),
    .nxt_table_o (nxt_table),
    .nxt_wp_o    (nxt_wp),
    .nxt_off_o   (nxt_off),
    .nxt_wid_o   (nxt_wid),
    .finish_o    (finish),
    .code_o      (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      table_q <= '0;
      wp_q    <= 1'b0;
      wr_q    <= 1'b0;
      step_q  <= '0;
      off_q   <= '0;
      wid_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      code_q  <= FLT_NONE;
      fstep_q <= '0;
      paddr_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_vaddr_i;
          table_q <= root_table_i;
          wp_q    <= 1'b1;
          wr_q    <= req_write_i;
          step_q  <= '0;
          off_q   <= root_off_i;
          wid_q   <= root_width_i;
          state_q <= ST_REQ;
        end
        ST_REQ: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (finish) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            fault_q <= (code != FLT_NONE);
            code_q  <= code;
            fstep_q <= step_q;
            paddr_q <= (code == FLT_NONE) ? nxt_table : '0;
          end else begin
            addr_q  <= nxt_addr;
            table_q <= nxt_table;
            wp_q    <= nxt_wp;
            off_q   <= nxt_off;
            wid_q   <= nxt_wid;
            step_q  <= step_q + STEP_W'(1);
            state_q <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign done_o          = done_q;
  assign fault_o         = fault_q;
  assign fault_code_o    = code_q;
  assign fault_step_o    = fstep_q;
  assign paddr_o         = paddr_q;

  a_r9_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
  a_r10_ready_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o);
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> done_o || ($stable(paddr_o) && $stable(fault_code_o) && $stable(fault_step_o)));
  a_r6_wp_no_regain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wp_q) |-> $past(req_valid_i && req_ready_o));
  a_r8_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= STEP_W'(MAX_STEPS - 1));
  a_r5_ok_needs_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) && !fault_o |-> $past(mem_rsp_data_i[1] && mem_rsp_data_i[0]));
  a_r7_invalid_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) && fault_code_o == 2'd1 |->
      $past(!mem_rsp_data_i[0] || mem_rsp_data_i[15:14] != 2'b00));
endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  localparam int AW = 48;
  localparam int MAXS = 6;
  localparam int SW = 3;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic          req_valid = 0, req_write = 0;
  logic [AW-1:0] req_vaddr = '0;
  logic [47:0]   root_table = '0;
  logic [5:0]    root_off = '0;
  logic [3:0]    root_width = '0;
  logic          req_ready, mem_req_valid, done, fault;
  logic          mem_ready = 0, rsp_valid = 0;
  logic [47:0]   mem_addr, paddr;
  logic [63:0]   rsp_data = '0;
  logic [1:0]    fcode;
  logic [SW-1:0] fstep;

  ptw_walker #(.AW(AW), .MAX_STEPS(MAXS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_write_i(req_write), .root_table_i(root_table),
    .root_off_i(root_off), .root_width_i(root_width), .mem_req_valid_o(mem_req_valid),
    .mem_req_ready_i(mem_ready), .mem_req_addr_o(mem_addr), .mem_rsp_valid_i(rsp_valid),
    .mem_rsp_data_i(rsp_data), .done_o(done), .fault_o(fault), .fault_code_o(fcode),
    .fault_step_o(fstep), .paddr_o(paddr));

  logic [63:0] mem [logic [47:0]];
  logic [47:0] rd_log [$];
  int n_chk = 0, n_bad = 0, cyc = 0;

  // memory model: one pending read, response 1..3 cycles after handshake
  logic        pend = 0;
  int          pcnt = 0;
  logic [47:0] paddr_pend = '0;
  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    mem_ready <= ($urandom % 2) == 0;
    if (pend) begin
      if (pcnt == 0) begin
        rsp_valid <= 1'b1;
        rsp_data  <= mem.exists(paddr_pend) ? mem[paddr_pend] : 64'd0;
        pend      <= 1'b0;
      end else pcnt <= pcnt - 1;
    end
    if (mem_req_valid && mem_ready) begin
      pend       <= 1'b1;
      pcnt       <= $urandom % 3;
      paddr_pend <= mem_addr;
      rd_log.push_back(mem_addr);
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [47:0] rd_addr_f(logic [47:0] a, logic [5:0] o, logic [3:0] w,
                                            logic [47:0] t);
    logic [15:0] ix = 16'(a >> o) & ((16'd1 << w) - 16'd1);
    return t + 48'({ix, 3'b000});
  endfunction

  function automatic logic [63:0] mk(logic [47:0] v, logic [5:0] o, logic [3:0] w,
                                     bit rw, bit clr, bit last, bit vld);
    return {v, 2'b00, w, o, rw, clr, last, vld};
  endfunction

  function automatic logic [63:0] rnd_desc();
    logic [63:0] d = {$urandom, $urandom};
    d[0] = ($urandom % 16) != 0;
    d[1] = ($urandom % 4) == 0;
    d[2] = ($urandom % 8) == 0;
    d[3] = ($urandom % 4) == 0;
    d[9:4] = 6'($urandom % 48);
    d[13:10] = 4'($urandom % 11);
    d[15:14] = 2'b00;
    return d;
  endfunction

  // reference walk; fill creates missing descriptors at random
  task automatic model(input logic [47:0] va, input bit wr, input logic [47:0] root,
                       input logic [5:0] o0, input logic [3:0] w0, input bit fill,
                       output logic [1:0] e_code, output int e_step, output logic [47:0] e_pa);
    logic [47:0] a = va, t = root, ra, v;
    logic [5:0] o = o0;
    logic [3:0] w = w0;
    logic [63:0] d, m;
    bit wp = 1;
    e_code = 0; e_step = 0; e_pa = 0;
    for (int s = 0; s < MAXS; s++) begin
      ra = rd_addr_f(a, o, w, t);
      if (!mem.exists(ra) && fill) mem[ra] = rnd_desc();
      d = mem.exists(ra) ? mem[ra] : 64'd0;
      e_step = s;
      if (!d[0] || d[15:14] != 0) begin e_code = 1; return; end
      v = d[63:16]; wp = wp & ~d[2];
      m = ((64'd1 << d[13:10]) - 1) << d[9:4];
      if (d[3]) a = (a & ~m[47:0]) | 48'(((64'(v) & ((64'd1 << d[13:10]) - 1)) << d[9:4]));
      else t = v;
      o = d[9:4]; w = d[13:10];
      if (d[1]) begin
        if (wr && !wp) e_code = 3; else e_pa = t;
        return;
      end
      if (s == MAXS - 1) begin e_code = 2; return; end
    end
  endtask

  task automatic walk(input logic [47:0] va, input bit wr, input logic [47:0] root,
                      input logic [5:0] o, input logic [3:0] w, input bit fill,
                      input bit poke, input string rq);
    logic [1:0] ec; int es; logic [47:0] ep, held;
    int t = 0;
    model(va, wr, root, o, w, fill, ec, es, ep);
    rd_log.delete();
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = wr;
    root_table = root; root_off = o; root_width = w;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      // R10: request while busy must be ignored
      for (int k = 0; k < 2; k++) begin
        req_valid = 1; req_vaddr = ~va; req_write = ~wr; root_table = ~root;
        chk(req_ready == 0, "R10", "ready while busy", req_ready, 0);
        @(negedge clk);
      end
      req_valid = 0;
    end
    while (!done && t < 200) begin @(negedge clk); t++; end
    chk(done == 1, rq, "done seen", done, 1);
    chk(fcode == ec, rq, "fault code", fcode, ec);
    chk(fault == (ec != 0), rq, "fault flag", fault, ec != 0);
    chk(paddr == ep, rq, "paddr", paddr, ep);
    if (ec != 0) chk(fstep == SW'(es), rq, "fault step", fstep, es);
    held = paddr;
    @(negedge clk);
    chk(done == 0, "R11", "done single cycle", done, 0);
    chk(paddr == held, "R11", "result held", paddr, held);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1", "ready", req_ready, 1);
    chk(mem_req_valid == 0, "R1", "mem valid", mem_req_valid, 0);
    chk(done == 0, "R1", "done", done, 0);
    chk(fault == 0, "R1", "fault", fault, 0);
    rst_n = 1;

    // R2 root indexing, R5 single-step finish
    mem.delete();
    mem[48'h1028] = mk(48'hABCDE000, 0, 0, 0, 0, 1, 1);
    walk(48'h0000_0000_5000, 0, 48'h1000, 6'd12, 4'd4, 0, 0, "R5");
    chk(rd_log.size() > 0 && rd_log[0] == 48'h1028, "R2", "first read addr",
        rd_log.size() > 0 ? rd_log[0] : 0, 48'h1028);

    // R3 next table and next field
    mem.delete();
    mem[48'h2010] = mk(48'h30000, 6'd20, 4'd2, 0, 0, 0, 1);
    mem[48'h30018] = mk(48'h777000, 0, 0, 0, 0, 1, 1);
    walk(48'h30_0002, 0, 48'h2000, 6'd0, 4'd3, 0, 0, "R3");
    chk(rd_log.size() > 1 && rd_log[1] == 48'h30018, "R3", "second read addr",
        rd_log.size() > 1 ? rd_log[1] : 0, 48'h30018);

    // R4 rewrite keeps table, next index from rewritten field
    mem.delete();
    mem[48'h4000] = mk(48'd3, 6'd8, 4'd2, 1, 0, 0, 1);
    mem[48'h4018] = mk(48'h5000, 0, 0, 0, 0, 1, 1);
    walk(48'h0, 0, 48'h4000, 6'd0, 4'd2, 0, 0, "R4");
    chk(paddr == 48'h5000, "R4", "paddr after rewrite", paddr, 48'h5000);
    chk(rd_log.size() > 1 && rd_log[1] == 48'h4018, "R4", "read after rewrite",
        rd_log.size() > 1 ? rd_log[1] : 0, 48'h4018);

    // R6 write permission removal, sticky across steps
    mem.delete();
    mem[48'h6000] = mk(48'h9000, 0, 0, 0, 1, 1, 1);
    walk(48'h0, 1, 48'h6000, 6'd0, 4'd0, 0, 0, "R6");
    chk(fcode == 2'd3, "R6", "write denied", fcode, 3);
    walk(48'h0, 0, 48'h6000, 6'd0, 4'd0, 0, 0, "R6");
    mem.delete();
    mem[48'h6100] = mk(48'h6200, 0, 0, 0, 1, 0, 1);
    mem[48'h6200] = mk(48'h7000, 0, 0, 0, 0, 1, 1);
    walk(48'h0, 1, 48'h6100, 6'd0, 4'd0, 0, 0, "R6");
    chk(fstep == 3'd1, "R6", "sticky denial step", fstep, 1);

    // R7 invalid at step 2, reserved bits at step 0
    mem.delete();
    mem[48'h8000] = mk(48'h8100, 0, 0, 0, 0, 0, 1);
    mem[48'h8100] = mk(48'h8200, 0, 0, 0, 0, 0, 1);
    walk(48'h0, 0, 48'h8000, 6'd0, 4'd0, 0, 0, "R7");
    chk(fstep == 3'd2 && fcode == 2'd1, "R7", "invalid step", fstep, 2);
    mem[48'h8300] = mk(48'h9000, 0, 0, 0, 0, 1, 1) | 64'h4000;
    walk(48'h0, 0, 48'h8300, 6'd0, 4'd0, 0, 0, "R7");

    // R8 cyclic table hits depth cap
    mem.delete();
    mem[48'hA000] = mk(48'hA000, 0, 0, 0, 0, 0, 1);
    walk(48'h0, 0, 48'hA000, 6'd0, 4'd0, 0, 0, "R8");
    chk(fcode == 2'd2 && fstep == SW'(MAXS - 1), "R8", "depth fault", fstep, MAXS - 1);
    chk(rd_log.size() == MAXS, "R9", "read count", rd_log.size(), MAXS);

    // R10 requests during walk ignored
    mem.delete();
    walk(48'h1234_5678_9ABC, 1, 48'h10_0000, 6'd4, 4'd6, 1, 1, "R10");

    // random walks
    for (int i = 0; i < 300; i++) begin
      mem.delete();
      a = {$urandom, $urandom};
      walk(a, 1'($urandom), 48'({$urandom, $urandom}) & ~48'h7,
           6'($urandom % 40), 4'($urandom % 11), 1, (i % 7) == 0, "R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule